// File: doc/BRIEF.md
# Reset Qualifier and Idle-Mode Clock Controller

This block sits between a microcontroller's external reset pin and its core. It decides whether a pulse on the reset pin is long enough to count as a real reset, and it controls idle mode, in which the CPU stops while its peripherals keep running. The pin is first passed through a two-flop synchronizer. Its length is then measured in machine-cycle strobes, and only a pulse that spans at least `MIN_MC` strobes raises the internal reset. Internal reset stays high while the pin is high. It drops on the first strobe after the synchronized pin has gone low.

Software writes 1 to the idle bit to stop the CPU clock enable. The peripheral clock enable, which covers the interrupt, timer and serial units, stays high. Idle ends in one of two ways. An enabled interrupt request makes the hardware clear the idle bit and emit a one-cycle wake pulse. A qualified reset returns everything to its reset state.

The reset qualifier uses states QS_RUN, QS_ARM and QS_HOLD, with these transitions:
- run→arm when the synchronized pin is high.
- arm→run when the pin drops.
- arm→hold on the `MIN_MC`-th strobe counted while the pin is high.
- hold→run on a strobe while the pin is low.

The idle controller uses states IS_RUN, IS_IDLE and IS_WAKE, with these transitions:
- run→idle on a write of 1.
- idle→wake on an interrupt request.
- idle→run on internal reset.
- wake→run always, after one cycle.
- Internal reset forces run from any state.

Top module: `rstidle_ctrl`

## Requirements
- R1: A reset-pin pulse during which fewer than 2 machine-cycle strobes are counted never raises `sys_rst`.
- R2: A reset-pin pulse that stays high across 2 or more strobes (after the 2-flop synchronizer) raises `sys_rst`, and `sys_rst` only rises in the cycle after a strobe.
- R3: `sys_rst` stays high while the synchronized pin is high, and falls only in the cycle after the first strobe seen once the synchronized pin is low.
- R4: A write with `idl_wdata`=1 while running sets `idl_bit` to 1 and clears `cpu_clk_en` from the next cycle, until idle ends.
- R5: `per_clk_en` stays 1 at all times, including in idle and during reset.
- R6: `irq_pend` during idle clears `idl_bit` and sets `cpu_clk_en` in the next cycle, and `wake_pulse` is high for exactly that one cycle.
- R7: `irq_pend` outside idle, and a write of 0 to the idle bit, change neither `idl_bit`, `cpu_clk_en` nor `wake_pulse`.
- R8: A qualified reset during idle clears `idl_bit`, restores `cpu_clk_en` and gives no `wake_pulse`.
- R9: After power-on reset, `sys_rst`=0, `idl_bit`=0, `cpu_clk_en`=1 and `wake_pulse`=0.
- R10: A write of 1 to the idle bit while `sys_rst` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw external reset pin, active high |
| mc_strobe | input | 1 | One-clock pulse per machine cycle |
| idl_wr | input | 1 | Write strobe for the idle-control bit |
| idl_wdata | input | 1 | Value written to the idle-control bit |
| irq_pend | input | 1 | Any enabled interrupt is requesting |
| sys_rst | output | 1 | Qualified internal reset, active high |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Interrupt/timer/serial clock enable |
| idl_bit | output | 1 | Read-back of the idle-control bit |
| wake_pulse | output | 1 | One-cycle pulse when idle ends on an interrupt |

## Verification
The assertions assume three things about the inputs:
- `mc_strobe` is a single-clock pulse.
- `rst_pin` may change at any time, but the qualifier only sees it after the synchronizer.
- Idle-bit writes come only from the running CPU.

The stimulus holds to these assumptions:
- The strobe is driven as a single clock pulse every fourth cycle.
- All inputs change on the falling edge.
- Pulse lengths are chosen well inside or well outside the two-strobe threshold, so no check depends on where the strobe lands within a pulse.

// File: rtl/rstidle_pkg.sv
package rstidle_pkg;
    typedef enum logic [1:0] {
        QS_RUN  = 2'd0,
        QS_ARM  = 2'd1,
        QS_HOLD = 2'd2
    } qual_state_e;

    typedef enum logic [1:0] {
        IS_RUN  = 2'd0,
        IS_IDLE = 2'd1,
        IS_WAKE = 2'd2
    } idle_state_e;
endpackage

// File: rtl/rstidle_qual.sv
module rstidle_qual
    import rstidle_pkg::*;
#(
    parameter int MIN_MC      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    input  logic mc_strobe,
    output logic sys_rst
);
    localparam int CNT_W = $clog2(MIN_MC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_MC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    qual_state_e            state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;

    // Synchronizer chain for the asynchronous pin
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rst_pin};
    end
    assign pin_s = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= QS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            QS_RUN: begin
                cnt_d = '0;
                if (pin_s) state_d = QS_ARM;
            end
            QS_ARM: begin
                if (!pin_s) begin
                    state_d = QS_RUN;
                    cnt_d   = '0;
                end else if (mc_strobe) begin
                    if (cnt_q == LAST) begin
                        state_d = QS_HOLD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            QS_HOLD: begin
                if (!pin_s && mc_strobe) state_d = QS_RUN;
            end
            default: state_d = QS_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        sys_rst = (state_q == QS_HOLD);
    end

    AST_RST_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst) |-> $past(mc_strobe)); // R2
    AST_RST_FALL_ON_STROBE: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> $past(mc_strobe)); // R3
    AST_RST_HELD_BY_PIN: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && pin_s) |=> sys_rst); // R3
    AST_NO_RST_FROM_RUN: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == QS_RUN) |=> !sys_rst); // R1
endmodule

// File: rtl/rstidle_idle.sv
module rstidle_idle
    import rstidle_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst,
    input  logic idl_wr,
    input  logic idl_wdata,
    input  logic irq_pend,
    output logic idl_bit,
    output logic cpu_clk_en,
    output logic wake_pulse
);
    idle_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= IS_RUN;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (sys_rst) begin
            state_d = IS_RUN;
        end else begin
            unique case (state_q)
                IS_RUN:  if (idl_wr && idl_wdata) state_d = IS_IDLE;
                IS_IDLE: if (irq_pend) state_d = IS_WAKE;
                IS_WAKE: state_d = IS_RUN;
                default: state_d = IS_RUN;
            endcase
        end
    end

    // Outputs
    always_comb begin
        idl_bit    = (state_q == IS_IDLE);
        cpu_clk_en = (state_q != IS_IDLE);
        wake_pulse = (state_q == IS_WAKE);
    end

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        wake_pulse |=> !wake_pulse); // R6
    AST_WAKE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wake_pulse) |-> $past(idl_bit) && $past(irq_pend)); // R6
    AST_IRQ_ENDS_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        (idl_bit && irq_pend) |=> (!idl_bit && cpu_clk_en)); // R6
    AST_RESET_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (!idl_bit && !wake_pulse)); // R8
    AST_IDLE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(idl_bit) |-> $past(idl_wr) && $past(idl_wdata) && !$past(sys_rst)); // R10
endmodule

// File: rtl/rstidle_ctrl.sv
module rstidle_ctrl #(
    parameter int MIN_MC      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    input  logic mc_strobe,
    input  logic idl_wr,
    input  logic idl_wdata,
    input  logic irq_pend,
    output logic sys_rst,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic idl_bit,
    output logic wake_pulse
);
    rstidle_qual #(
        .MIN_MC      (MIN_MC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_qual (
        .clk       (clk),
        .por_n     (por_n),
        .rst_pin   (rst_pin),
        .mc_strobe (mc_strobe),
        .sys_rst   (sys_rst)
    );

    rstidle_idle u_idle (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst    (sys_rst),
        .idl_wr     (idl_wr),
        .idl_wdata  (idl_wdata),
        .irq_pend   (irq_pend),
        .idl_bit    (idl_bit),
        .cpu_clk_en (cpu_clk_en),
        .wake_pulse (wake_pulse)
    );

    // Interrupt, timer and serial units never stop in idle
    assign per_clk_en = 1'b1;
endmodule

// File: tb/rstidle_ctrl_tb.sv
`timescale 1ns/1ps
module rstidle_ctrl_tb;
    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_pin = 1'b0;
    logic mc_strobe = 1'b0;
    logic idl_wr = 1'b0;
    logic idl_wdata = 1'b0;
    logic irq_pend = 1'b0;
    logic sys_rst, cpu_clk_en, per_clk_en, idl_bit, wake_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int strobe_div = 0;

    always #2 clk = ~clk;

    rstidle_ctrl u_dut (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .mc_strobe(mc_strobe),
        .idl_wr(idl_wr), .idl_wdata(idl_wdata), .irq_pend(irq_pend),
        .sys_rst(sys_rst), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .idl_bit(idl_bit), .wake_pulse(wake_pulse)
    );

    // Machine-cycle strobe: one clock in four
    always @(negedge clk) begin
        strobe_div <= (strobe_div + 1) % 4;
        mc_strobe  <= (strobe_div == 3);
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Vector: {wr, wdata, irq, exp_idl, exp_cpu_en, exp_wake}
    localparam logic [5:0] VEC [9] = '{
        6'b110_100,  // R4 enter idle
        6'b000_100,  // R4 stay idle
        6'b001_011,  // R6 wake
        6'b000_010,  // R6 pulse ends
        6'b001_010,  // R7 irq while running
        6'b100_010,  // R7 write 0
        6'b111_100,  // R4 write 1 with irq while running
        6'b001_011,  // R6 wake again
        6'b000_010   // R6 pulse ends
    };

    initial begin
        cyc(3);
        por_n = 1'b1;
        cyc(2);
        chk("R9 sys_rst", sys_rst, 1'b0);
        chk("R9 idl_bit", idl_bit, 1'b0);
        chk("R9 cpu_clk_en", cpu_clk_en, 1'b1);
        chk("R9 wake_pulse", wake_pulse, 1'b0);
        chk("R5 per_clk_en", per_clk_en, 1'b1);

        for (int v = 0; v < 9; v++) begin
            idl_wr    = VEC[v][5];
            idl_wdata = VEC[v][4];
            irq_pend  = VEC[v][3];
            @(negedge clk);
            idl_wr = 1'b0; idl_wdata = 1'b0; irq_pend = 1'b0;
            chk("R4/R6/R7 idl_bit", idl_bit, VEC[v][2]);
            chk("R4/R6/R7 cpu_clk_en", cpu_clk_en, VEC[v][1]);
            chk("R6/R7 wake_pulse", wake_pulse, VEC[v][0]);
            chk("R5 per_clk_en", per_clk_en, 1'b1);
        end

        // R1: short pulse, at most one strobe counted
        rst_pin = 1'b1;
        cyc(4);
        rst_pin = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk("R1 short pulse ignored", sys_rst, 1'b0);
        end

        // R8: qualified reset while idle
        idl_wr = 1'b1; idl_wdata = 1'b1;
        @(negedge clk);
        idl_wr = 1'b0; idl_wdata = 1'b0;
        chk("R4 idle before reset", idl_bit, 1'b1);
        rst_pin = 1'b1;
        cyc(16);
        chk("R2 long pulse resets", sys_rst, 1'b1);
        chk("R8 idle cleared", idl_bit, 1'b0);
        chk("R8 cpu_clk_en", cpu_clk_en, 1'b1);
        chk("R8 no wake_pulse", wake_pulse, 1'b0);
        chk("R5 per_clk_en in reset", per_clk_en, 1'b1);

        // R10: write during reset ignored
        idl_wr = 1'b1; idl_wdata = 1'b1;
        @(negedge clk);
        idl_wr = 1'b0; idl_wdata = 1'b0;
        chk("R10 write ignored", idl_bit, 1'b0);
        cyc(8);
        chk("R3 held while pin high", sys_rst, 1'b1);

        rst_pin = 1'b0;
        @(negedge clk);
        chk("R3 not released at once", sys_rst, 1'b1);
        cyc(10);
        chk("R3 released after strobe", sys_rst, 1'b0);
        chk("R10 still not idle", idl_bit, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule